// File: doc/BRIEF.md
# Paged Serial Word Register Frontend

This block sits behind a serial control port that has already assembled its bits into parallel 16-bit words. Each accepted word arrives with a valid strobe and a transfer length. The frontend splits the stream into command words and data words. From each command it decodes a direction flag, a page number and a register offset. It then drives a generic register bank with single-cycle read or write strobes. Three pages exist: data (0), control (1) and audio (2).

An all-zero word asks the block to clock out read data. Every read advances the offset by one, so a host can stream consecutive registers by sending zero words. The block flags protocol errors: a data word that arrives while a read is pending, a read with no read command behind it, an access to a page that does not exist, and a transfer of the wrong length. A dedicated key written to one control register requests a full soft reset.

Top module: `spf_frontend`

## Requirements
- R1: After a synchronous reset, and at any later reset, the engine waits for a command, the stored page, offset and direction are zero, and no strobe, response or flag is active.
- R2: When a 16-bit non-zero word arrives while no command is pending, it is taken as a command. Bit 15 set means read, bits 14:11 are the page and bits 10:5 are the offset. No register strobe fires in that cycle.
- R3: The word that follows a write command fires rb_wr_en in the same cycle, with the stored page and offset and the word on rb_wdata. The engine then waits for a new command.
- R4: A read fires rb_rd_en in the same cycle as the incoming word, using the stored page and offset. One cycle later out_valid is high and out_word equals the rb_rdata sampled in that cycle. A read occurs when the word is zero or a read command is pending.
- R5: Each read increments the stored offset by one, wrapping from 63 to 0, and returns the engine to waiting for a command. Further zero words therefore read successive offsets.
- R6: A non-zero word that arrives while a read command is pending performs that read, raises err_overrun one cycle later, and is then decoded as the next command.
- R7: A read issued when the most recently decoded command was not a read still takes place, but raises err_underrun one cycle later.
- R8: A word whose in_len is not 16 fires no strobe and leaves the engine state unchanged. One cycle later it yields out_valid with out_word zero and err_len high.
- R9: A read or write aimed at a page number above 2 fires no strobe, returns zero data and raises err_page one cycle later. The engine advances exactly as it would for a legal page.
- R10: Write data 0xBB00 aimed at control page 1, offset 4, fires no write strobe and pulses soft_rst one cycle later, and the engine returns to its reset state. Any other data at that location fires neither a write strobe nor soft_rst.
- R11: A zero word that arrives while a write command is pending performs a read at the stored location, flagged as an underrun. The zero word is then taken as a write command to page 0, offset 0, and the next word is written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One incoming word this cycle |
| in_len | input | 6 | Length of the incoming transfer in bits |
| in_word | input | 16 | Incoming word |
| rb_rd_en | output | 1 | Register bank read strobe |
| rb_wr_en | output | 1 | Register bank write strobe |
| rb_page | output | 4 | Page of the access |
| rb_offset | output | 6 | Register offset of the access |
| rb_wdata | output | 16 | Write data |
| rb_rdata | input | 16 | Read data, sampled in the read strobe cycle |
| out_valid | output | 1 | Response word valid |
| out_word | output | 16 | Response word (read data or zero) |
| err_overrun | output | 1 | Data word arrived during a pending read |
| err_underrun | output | 1 | Read with no read command behind it |
| err_page | output | 1 | Access to a page that does not exist |
| err_len | output | 1 | Transfer length other than 16 |
| soft_rst | output | 1 | Soft reset request pulse |

## Verification
The register strobes, page, offset and write data are combinational from the incoming word. The bench drives each word just after a falling edge and samples these signals one time unit later, before the rising edge. The response word and all flags pass through one register, so they are read at the following falling edge, one cycle after the word. Each vector in the table pairs a word and the read data presented for it with both sets of expected values. Tests that rely on hidden state, such as the offset wrap or the state held across a rejected transfer, place a later word whose strobe reveals that state.

// File: rtl/spf_pkg.sv
package spf_pkg;
    // page codes of the register bank
    typedef enum logic [1:0] {
        PG_DATA  = 2'd0,
        PG_CTRL  = 2'd1,
        PG_AUDIO = 2'd2
    } page_code_e;

    localparam int DEF_WORD_W    = 16;
    localparam int DEF_PAGE_W    = 4;
    localparam int DEF_OFF_W     = 6;
    localparam int DEF_LEN_W     = 6;
    localparam int DEF_NUM_PAGES = 3;
endpackage

// File: rtl/spf_cmd_decode.sv
module spf_cmd_decode #(
    parameter int WORD_W = 16,
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 6
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_read,
    output logic              is_zero,
    output logic [PAGE_W-1:0] page,
    output logic [OFF_W-1:0]  offset
);
    localparam int PAGE_LSB = WORD_W - 1 - PAGE_W;
    localparam int OFF_LSB  = PAGE_LSB - OFF_W;

    always_comb begin
        is_read = word[WORD_W-1];
        is_zero = (word == '0);
        page    = word[PAGE_LSB +: PAGE_W];
        offset  = word[OFF_LSB +: OFF_W];
    end
endmodule

// File: rtl/spf_engine.sv
module spf_engine #(
    parameter int              WORD_W    = 16,
    parameter int              PAGE_W    = 4,
    parameter int              OFF_W     = 6,
    parameter int              NUM_PAGES = 3,
    parameter int              KEY_PAGE  = 1,
    parameter int              KEY_OFF   = 4,
    parameter logic [WORD_W-1:0] KEY_WORD = 16'hBB00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,       // valid word of legal length
    input  logic [WORD_W-1:0] word,
    input  logic              dec_read,
    input  logic              dec_zero,
    input  logic [PAGE_W-1:0] dec_page,
    input  logic [OFF_W-1:0]  dec_off,
    input  logic [WORD_W-1:0] rb_rdata,
    output logic              rb_rd_en,
    output logic              rb_wr_en,
    output logic [PAGE_W-1:0] rb_page,
    output logic [OFF_W-1:0]  rb_offset,
    output logic [WORD_W-1:0] rb_wdata,
    output logic [WORD_W-1:0] rsp_word,
    output logic              f_ovr,
    output logic              f_und,
    output logic              f_page,
    output logic              f_srst
);
    typedef struct packed {
        logic              pending;
        logic              cmd_rd;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  offset;
    } eng_t;

    localparam eng_t ENG_RST = '{pending: 1'b0, cmd_rd: 1'b0, page: '0, offset: '0};

    eng_t st_q, st_d, mid;
    logic do_read, do_write, page_ok;

    always_comb begin
        st_d     = st_q;
        mid      = st_q;
        rb_rd_en = 1'b0;
        rb_wr_en = 1'b0;
        rsp_word = '0;
        f_ovr    = 1'b0;
        f_und    = 1'b0;
        f_page   = 1'b0;
        f_srst   = 1'b0;
        page_ok  = (int'(st_q.page) < NUM_PAGES);
        do_read  = dec_zero || (st_q.pending && st_q.cmd_rd);
        do_write = !dec_zero || (st_q.pending && !st_q.cmd_rd);
        if (take) begin
            // read half first: it uses the location stored before this word
            if (do_read) begin
                f_und = !st_q.cmd_rd;
                f_ovr = st_q.pending && st_q.cmd_rd && !dec_zero;
                if (page_ok) begin
                    rb_rd_en = 1'b1;
                    rsp_word = rb_rdata;
                end else begin
                    f_page = 1'b1;
                end
                mid.offset  = st_q.offset + OFF_W'(1);
                mid.pending = 1'b0;
            end
            // write half: command decode or write data
            if (do_write) begin
                if (!mid.pending) begin
                    mid.pending = 1'b1;
                    mid.cmd_rd  = dec_read;
                    mid.page    = dec_page;
                    mid.offset  = dec_off;
                end else begin
                    mid.pending = 1'b0;
                    if (!page_ok) begin
                        f_page = 1'b1;
                    end else if (int'(st_q.page) == KEY_PAGE && int'(st_q.offset) == KEY_OFF) begin
                        if (word == KEY_WORD) begin
                            f_srst = 1'b1;
                            mid    = ENG_RST;
                        end
                    end else begin
                        rb_wr_en = 1'b1;
                    end
                end
            end
            st_d = mid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ENG_RST;
        else     st_q <= st_d;
    end

    assign rb_page   = st_q.page;
    assign rb_offset = st_q.offset;
    assign rb_wdata  = word;
endmodule

// File: rtl/spf_resp.sv
module spf_resp #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              len_ok,
    input  logic [WORD_W-1:0] rsp_word,
    input  logic              f_ovr,
    input  logic              f_und,
    input  logic              f_page,
    input  logic              f_srst,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              err_overrun,
    output logic              err_underrun,
    output logic              err_page,
    output logic              err_len,
    output logic              soft_rst
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic              ovr;
        logic              und;
        logic              pg;
        logic              len;
        logic              srst;
    } rsp_t;

    rsp_t r_q, r_d;

    always_comb begin
        logic acc;
        acc       = in_valid && len_ok;
        r_d       = '0;
        r_d.valid = in_valid;
        r_d.len   = in_valid && !len_ok;
        if (acc) begin
            r_d.word = rsp_word;
            r_d.ovr  = f_ovr;
            r_d.und  = f_und;
            r_d.pg   = f_page;
            r_d.srst = f_srst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign out_valid    = r_q.valid;
    assign out_word     = r_q.word;
    assign err_overrun  = r_q.ovr;
    assign err_underrun = r_q.und;
    assign err_page     = r_q.pg;
    assign err_len      = r_q.len;
    assign soft_rst     = r_q.srst;
endmodule

// File: rtl/spf_frontend.sv
module spf_frontend #(
    parameter int WORD_W    = spf_pkg::DEF_WORD_W,
    parameter int PAGE_W    = spf_pkg::DEF_PAGE_W,
    parameter int OFF_W     = spf_pkg::DEF_OFF_W,
    parameter int LEN_W     = spf_pkg::DEF_LEN_W,
    parameter int NUM_PAGES = spf_pkg::DEF_NUM_PAGES,
    parameter int KEY_OFF   = 4,
    parameter logic [WORD_W-1:0] KEY_WORD = 16'hBB00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [WORD_W-1:0] in_word,
    output logic              rb_rd_en,
    output logic              rb_wr_en,
    output logic [PAGE_W-1:0] rb_page,
    output logic [OFF_W-1:0]  rb_offset,
    output logic [WORD_W-1:0] rb_wdata,
    input  logic [WORD_W-1:0] rb_rdata,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              err_overrun,
    output logic              err_underrun,
    output logic              err_page,
    output logic              err_len,
    output logic              soft_rst
);
    localparam int KEY_PAGE = int'(spf_pkg::PG_CTRL);

    logic              len_ok, take;
    logic              dec_read, dec_zero;
    logic [PAGE_W-1:0] dec_page;
    logic [OFF_W-1:0]  dec_off;
    logic [WORD_W-1:0] rsp_word;
    logic              f_ovr, f_und, f_page, f_srst;

    assign len_ok = (int'(in_len) == WORD_W);
    assign take   = in_valid && len_ok;

    spf_cmd_decode #(.WORD_W(WORD_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_dec (
        .word    (in_word),
        .is_read (dec_read),
        .is_zero (dec_zero),
        .page    (dec_page),
        .offset  (dec_off)
    );

    spf_engine #(
        .WORD_W(WORD_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .NUM_PAGES(NUM_PAGES),
        .KEY_PAGE(KEY_PAGE), .KEY_OFF(KEY_OFF), .KEY_WORD(KEY_WORD)
    ) u_eng (
        .clk, .rst, .take,
        .word     (in_word),
        .dec_read, .dec_zero, .dec_page, .dec_off,
        .rb_rdata, .rb_rd_en, .rb_wr_en, .rb_page, .rb_offset, .rb_wdata,
        .rsp_word, .f_ovr, .f_und, .f_page, .f_srst
    );

    spf_resp #(.WORD_W(WORD_W)) u_rsp (
        .clk, .rst, .in_valid, .len_ok, .rsp_word,
        .f_ovr, .f_und, .f_page, .f_srst,
        .out_valid, .out_word, .err_overrun, .err_underrun,
        .err_page, .err_len, .soft_rst
    );
endmodule

// File: rtl/spf_frontend_chk.sv
module spf_frontend_chk #(
    parameter int WORD_W    = 16,
    parameter int PAGE_W    = 4,
    parameter int LEN_W     = 6,
    parameter int NUM_PAGES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [LEN_W-1:0]  in_len,
    input logic [WORD_W-1:0] in_word,
    input logic              rb_rd_en,
    input logic              rb_wr_en,
    input logic [PAGE_W-1:0] rb_page,
    input logic [WORD_W-1:0] rb_rdata,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              err_overrun,
    input logic              err_underrun,
    input logic              err_len,
    input logic              soft_rst
);
    // one access kind per word (R3, R4)
    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !(rb_rd_en && rb_wr_en));

    // strobes only for a valid word of legal length (R8)
    assert_strobe_needs_word_R8: assert property (@(posedge clk) disable iff (rst)
        (rb_rd_en || rb_wr_en) |-> (in_valid && int'(in_len) == WORD_W));

    // strobes never reach a missing page (R9)
    assert_legal_page_R9: assert property (@(posedge clk) disable iff (rst)
        (rb_rd_en || rb_wr_en) |-> (int'(rb_page) < NUM_PAGES));

    // read data returns one cycle after the strobe (R4)
    assert_read_return_R4: assert property (@(posedge clk) disable iff (rst)
        rb_rd_en |=> (out_valid && out_word == $past(rb_rdata)));

    // every word gets exactly one response a cycle later (R4)
    assert_resp_per_word_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_resp_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // soft reset only follows the key word (R10)
    assert_srst_key_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> $past(in_valid && in_word == 16'hBB00));

    // a rejected length excludes the protocol flags (R6, R7)
    assert_flag_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_len, err_overrun, err_underrun}));
endmodule

bind spf_frontend spf_frontend_chk #(
    .WORD_W(WORD_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W), .NUM_PAGES(NUM_PAGES)
) u_chk (
    .clk, .rst, .in_valid, .in_len, .in_word, .rb_rd_en, .rb_wr_en, .rb_page,
    .rb_rdata, .out_valid, .out_word, .err_overrun, .err_underrun, .err_len, .soft_rst
);

// File: tb/spf_frontend_test.sv
module spf_frontend_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  in_len = 6'd16;
    logic [15:0] in_word = '0;
    logic [15:0] rb_rdata = '0;
    logic        rb_rd_en, rb_wr_en;
    logic [3:0]  rb_page;
    logic [5:0]  rb_offset;
    logic [15:0] rb_wdata, out_word;
    logic        out_valid, err_overrun, err_underrun, err_page, err_len, soft_rst;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    spf_frontend uut (
        .clk, .rst, .in_valid, .in_len, .in_word, .rb_rd_en, .rb_wr_en,
        .rb_page, .rb_offset, .rb_wdata, .rb_rdata, .out_valid, .out_word,
        .err_overrun, .err_underrun, .err_page, .err_len, .soft_rst
    );

    // flags in the order {soft_rst, overrun, underrun, page, len}
    typedef struct packed {
        logic [5:0]  len;
        logic [15:0] word;
        logic [15:0] rdata;
        logic        rd;
        logic        wr;
        logic [3:0]  page;
        logic [5:0]  off;
        logic [15:0] wdata;
        logic [15:0] out;
        logic [4:0]  flg;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{6'd16, 16'h0000, 16'h1111, 1'b1, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h1111, 5'b00100, 4'd7},  // R7 read after reset
        '{6'd16, 16'h0860, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2 wr cmd p1 o3
        '{6'd16, 16'h00AB, 16'h0000, 1'b0, 1'b1, 4'd1, 6'd3,  16'h00AB, 16'h0000, 5'b00000, 4'd3},  // R3
        '{6'd16, 16'h9140, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2 rd cmd p2 o10
        '{6'd16, 16'h0000, 16'h2222, 1'b1, 1'b0, 4'd2, 6'd10, 16'h0000, 16'h2222, 5'b00000, 4'd4},  // R4
        '{6'd16, 16'h0000, 16'h3333, 1'b1, 1'b0, 4'd2, 6'd11, 16'h0000, 16'h3333, 5'b00000, 4'd5},  // R5 increment
        '{6'd16, 16'h87E0, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2 rd cmd p0 o63
        '{6'd16, 16'h0000, 16'h4444, 1'b1, 1'b0, 4'd0, 6'd63, 16'h0000, 16'h4444, 5'b00000, 4'd5},  // R5
        '{6'd16, 16'h0000, 16'h5555, 1'b1, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h5555, 5'b00000, 4'd5},  // R5 wrap
        '{6'd16, 16'h8840, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2 rd cmd p1 o2
        '{6'd16, 16'h10A0, 16'h6666, 1'b1, 1'b0, 4'd1, 6'd2,  16'h0000, 16'h6666, 5'b01000, 4'd6},  // R6 overrun
        '{6'd16, 16'h0F0F, 16'h0000, 1'b0, 1'b1, 4'd2, 6'd5,  16'h0F0F, 16'h0000, 5'b00000, 4'd6},  // R6 decoded cmd
        '{6'd8,  16'h1234, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00001, 4'd8},  // R8
        '{6'd16, 16'h0020, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2 wr cmd p0 o1
        '{6'd12, 16'h5678, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00001, 4'd8},  // R8 mid command
        '{6'd16, 16'h00CD, 16'h0000, 1'b0, 1'b1, 4'd0, 6'd1,  16'h00CD, 16'h0000, 5'b00000, 4'd8},  // R8 state kept
        '{6'd16, 16'h2800, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2 wr cmd p5
        '{6'd16, 16'h0077, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00010, 4'd9},  // R9 write
        '{6'd16, 16'h98E0, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2 rd cmd p3 o7
        '{6'd16, 16'h0000, 16'h9999, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00010, 4'd9},  // R9 read
        '{6'd16, 16'h0000, 16'hAAAA, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00010, 4'd9},  // R9 again
        '{6'd16, 16'h0880, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2 wr cmd p1 o4
        '{6'd16, 16'h1234, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd10}, // R10 wrong key
        '{6'd16, 16'h0880, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2
        '{6'd16, 16'hBB00, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b10000, 4'd10}, // R10 key
        '{6'd16, 16'h0000, 16'hBEEF, 1'b1, 1'b0, 4'd0, 6'd0,  16'h0000, 16'hBEEF, 5'b00100, 4'd10}, // R10 state cleared
        '{6'd16, 16'h1120, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0,  16'h0000, 16'h0000, 5'b00000, 4'd2},  // R2 wr cmd p2 o9
        '{6'd16, 16'h0000, 16'h7777, 1'b1, 1'b0, 4'd2, 6'd9,  16'h0000, 16'h7777, 5'b00100, 4'd11}, // R11
        '{6'd16, 16'h0042, 16'h0000, 1'b0, 1'b1, 4'd0, 6'd0,  16'h0042, 16'h0000, 5'b00000, 4'd11}  // R11 zero as cmd
    };

    task automatic check(input bit ok, input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [4:0] flg;
        @(negedge clk);
        in_valid = 1'b1;
        in_len   = v.len;
        in_word  = v.word;
        rb_rdata = v.rdata;
        #1;
        check(rb_rd_en == v.rd, int'(v.req), "rd_en", 16'(rb_rd_en), 16'(v.rd));
        check(rb_wr_en == v.wr, int'(v.req), "wr_en", 16'(rb_wr_en), 16'(v.wr));
        if (v.rd || v.wr) begin
            check(rb_page == v.page, int'(v.req), "page", 16'(rb_page), 16'(v.page));
            check(rb_offset == v.off, int'(v.req), "offset", 16'(rb_offset), 16'(v.off));
        end
        if (v.wr) check(rb_wdata == v.wdata, int'(v.req), "wdata", rb_wdata, v.wdata);
        @(negedge clk);
        in_valid = 1'b0;
        rb_rdata = '0;
        flg = {soft_rst, err_overrun, err_underrun, err_page, err_len};
        check(out_valid == 1'b1, int'(v.req), "out_valid", 16'(out_valid), 16'd1);
        check(out_word == v.out, int'(v.req), "out_word", out_word, v.out);
        check(flg == v.flg, int'(v.req), "flags", 16'(flg), 16'(v.flg));
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog: actual=%h expected=%h", 16'd0, 16'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state at the ports
        check(!rb_rd_en && !rb_wr_en, 1, "strobes", 16'({rb_rd_en, rb_wr_en}), 16'd0);
        check(!out_valid && out_word == 16'h0, 1, "response", out_word, 16'h0);
        check({soft_rst, err_overrun, err_underrun, err_page, err_len} == 5'b0, 1, "flags",
              16'({soft_rst, err_overrun, err_underrun, err_page, err_len}), 16'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: reset in the middle of a pending read command clears it
        v = '{6'd16, 16'h8A00, 16'h0000, 1'b0, 1'b0, 4'd0, 6'd0, 16'h0000, 16'h0000, 5'b00000, 4'd1};
        run_vec(v);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check(!out_valid, 1, "out_valid after reset", 16'(out_valid), 16'd0);
        v = '{6'd16, 16'h0000, 16'hC0DE, 1'b1, 1'b0, 4'd0, 6'd0, 16'h0000, 16'hC0DE, 5'b00100, 4'd1};
        run_vec(v);

        // R8: no response strobe without a word
        @(negedge clk);
        check(!out_valid, 8, "idle out_valid", 16'(out_valid), 16'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule